// File: doc/BRIEF.md
# USB Host Interrupt Aggregator

This block folds the interrupt state of a multi-channel USB host controller into a single level-sensitive interrupt line. Each channel owns an event status register and a mask register. A channel whose unmasked status is nonzero raises one bit in a channel summary vector. The summary vector is gated by a summary mask to drive one read-only "channel pending" bit inside a 32-bit global status register. That global status is gated by a global mask and a global enable bit to produce the interrupt output.

Event sources raise status bits with single-cycle set pulses, one vector per channel and one for the global register. Software reaches every register through a simple word-addressed read/write port with combinational read data. It clears status bits by writing ones. The interrupt output is registered, so it follows the register state with one cycle of latency. It changes only when the gated level differs from its current value.

Top module: `usb_irq_aggregator`

## Requirements
- R1: `irq_o` equals (enable AND any bit of (global status view AND global mask)) as computed from the register state of the previous cycle. It therefore changes exactly one clock after the state that causes it.
- R2: Summary bit c (read at word 0x04, bit c) is 1 exactly when channel c's status AND channel c's mask is nonzero. It returns to 0 as soon as that product becomes zero.
- R3: Global status bit 25 (the channel-pending bit) reads 1 exactly when summary AND summary mask (word 0x05) is nonzero. Writing 1 to this bit has no effect.
- R4: Channel c occupies words 0x80+8c to 0x80+8c+7. Its status is at offset 2 and its mask at offset 3, so the channel number is the word index within the channel region shifted right by 3. Unused words in both regions read 0.
- R5: A set pulse on `ch_set_i[c*CH_W +: CH_W]` ORs into channel c's status. Raising a bit that is already set leaves the register unchanged. A set in the same cycle as a clear of the same bit wins.
- R6: Channel status is write-1-to-clear: bits written 1 clear and bits written 0 keep their value. Channel mask is plain read/write.
- R7: Global status (word 0x00) bits other than bit 25 are raised by `glb_set_i` and cleared by writing 1. Bit 25 of `glb_set_i` is ignored. Raising a bit that is already set has no effect.
- R8: After reset, all status, mask, summary and summary-mask registers read 0, the enable is off, and `irq_o` is 0.
- R9: The summary and summary-mask registers hold one bit per channel (16 by default). Bits above the channel count read 0.
- R10: The global enable is bit 0 of the configuration word 0x02. While it is 0, `irq_o` stays 0 whatever the status and masks hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW (8) | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| ch_set_i | input | NUM_CH*CH_W | Per-channel status set pulses |
| glb_set_i | input | 32 | Global status set pulses |
| irq_o | output | 1 | Level interrupt output |

## Verification
On every cycle, the embedded assertions check the following: set pulses land in channel status, write-1-to-clear empties the written bits, a zeroed channel mask drops that channel's summary, and a zeroed summary mask drops the channel-pending bit. They also check that global status clears on write, that a disabled block never asserts the interrupt, and that the interrupt holds while its inputs hold. Other behaviours are shown only by the bench's scenarios: the address layout of the channel registers, the read-only nature of bit 25, set-over-clear priority, and the exact one-cycle interrupt latency. The scenarios also cover the cascade from a channel event through summary and global status to the output line, and the reset values.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  // global region word offsets
  localparam int GSTS_WORD = 0;
  localparam int GMSK_WORD = 1;
  localparam int CFG_WORD  = 2;
  localparam int SUM_WORD  = 4;
  localparam int SMSK_WORD = 5;
  // channel region: 8 words per channel
  localparam int CH_STRIDE_LOG2 = 3;
  localparam int CH_STS_OFS = 2;
  localparam int CH_MSK_OFS = 3;
  localparam int DW = 32;
  localparam int CHIRQ_BIT = 25;
endpackage

// File: rtl/irq_chan_regs.sv
module irq_chan_regs #(
  parameter int CH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] set_i,
  input  logic            sts_wr_i,
  input  logic            msk_wr_i,
  input  logic [CH_W-1:0] wdata_i,
  output logic [CH_W-1:0] sts_o,
  output logic [CH_W-1:0] msk_o,
  output logic            sum_o
);
  logic [CH_W-1:0] sts_q, msk_q, clr;

  assign clr = sts_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i;  // set wins
      if (msk_wr_i) msk_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign sum_o = |(sts_q & msk_q);

  assert_sts_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  assert_sts_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && set_i == '0) |=> ((sts_q & $past(wdata_i)) == '0));

  assert_sum_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_wr_i && wdata_i == '0) |=> !sum_o);
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] sum_i,
  input  logic              smsk_wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] smsk_o,
  output logic              chirq_o
);
  logic [NUM_CH-1:0] smsk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        smsk_q <= '0;
    else if (smsk_wr_i) smsk_q <= wdata_i;
  end

  assign smsk_o  = smsk_q;
  assign chirq_o = |(sum_i & smsk_q);

  assert_chirq_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smsk_wr_i && wdata_i == '0) |=> !chirq_o);
endmodule

// File: rtl/irq_glb_regs.sv
module irq_glb_regs
  import usb_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          chirq_i,
  input  logic          gsts_wr_i,
  input  logic          gmsk_wr_i,
  input  logic          cfg_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] gsts_o,
  output logic [DW-1:0] gmsk_o,
  output logic          en_o,
  output logic          irq_o
);
  localparam logic [DW-1:0] CHMASK = DW'(1) << CHIRQ_BIT;

  logic [DW-1:0] gsts_q, gmsk_q, clr, view;
  logic          en_q, irq_q;

  assign clr  = gsts_wr_i ? wdata_i : '0;
  assign view = gsts_q | (chirq_i ? CHMASK : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gsts_q <= '0;
      gmsk_q <= '0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      gsts_q <= ((gsts_q & ~clr) | set_i) & ~CHMASK;
      if (gmsk_wr_i) gmsk_q <= wdata_i;
      if (cfg_wr_i)  en_q   <= wdata_i[0];
      irq_q <= en_q & (|(view & gmsk_q));
    end
  end

  assign gsts_o = view;
  assign gmsk_o = gmsk_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  assert_gsts_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsts_wr_i |=> ((gsts_q & $past(wdata_i & ~set_i)) == '0));

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !irq_q);

  assert_irq_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(view) && $stable(gmsk_q) && $stable(en_q)) |=> $stable(irq_q));
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
  import usb_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 8,
  localparam int CIW   = $clog2(NUM_CH),
  localparam int AW    = CIW + CH_STRIDE_LOG2 + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic [NUM_CH*CH_W-1:0] ch_set_i,
  input  logic [DW-1:0]          glb_set_i,
  output logic                   irq_o
);
  logic                      is_ch;
  logic [CIW-1:0]            ch_idx;
  logic [CH_STRIDE_LOG2-1:0] ch_ofs;
  logic [AW-2:0]             lo;

  assign is_ch  = addr_i[AW-1];
  assign ch_idx = addr_i[AW-2:CH_STRIDE_LOG2];
  assign ch_ofs = addr_i[CH_STRIDE_LOG2-1:0];
  assign lo     = addr_i[AW-2:0];

  logic g_sel_gsts, g_sel_gmsk, g_sel_cfg, g_sel_sum, g_sel_smsk;
  assign g_sel_gsts = !is_ch && lo == (AW-1)'(GSTS_WORD);
  assign g_sel_gmsk = !is_ch && lo == (AW-1)'(GMSK_WORD);
  assign g_sel_cfg  = !is_ch && lo == (AW-1)'(CFG_WORD);
  assign g_sel_sum  = !is_ch && lo == (AW-1)'(SUM_WORD);
  assign g_sel_smsk = !is_ch && lo == (AW-1)'(SMSK_WORD);

  logic [CH_W-1:0]   ch_sts [NUM_CH];
  logic [CH_W-1:0]   ch_msk [NUM_CH];
  logic [NUM_CH-1:0] summary;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_i && is_ch && ch_idx == CIW'(c);
    irq_chan_regs #(.CH_W(CH_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (ch_set_i[c*CH_W +: CH_W]),
      .sts_wr_i (hit && ch_ofs == CH_STRIDE_LOG2'(CH_STS_OFS)),
      .msk_wr_i (hit && ch_ofs == CH_STRIDE_LOG2'(CH_MSK_OFS)),
      .wdata_i  (wdata_i[CH_W-1:0]),
      .sts_o    (ch_sts[c]),
      .msk_o    (ch_msk[c]),
      .sum_o    (summary[c])
    );
  end

  logic [NUM_CH-1:0] smsk;
  logic              chirq;

  irq_summary #(.NUM_CH(NUM_CH)) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sum_i     (summary),
    .smsk_wr_i (wr_i && g_sel_smsk),
    .wdata_i   (wdata_i[NUM_CH-1:0]),
    .smsk_o    (smsk),
    .chirq_o   (chirq)
  );

  logic [DW-1:0] gsts, gmsk;
  logic          en;

  irq_glb_regs u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (glb_set_i),
    .chirq_i   (chirq),
    .gsts_wr_i (wr_i && g_sel_gsts),
    .gmsk_wr_i (wr_i && g_sel_gmsk),
    .cfg_wr_i  (wr_i && g_sel_cfg),
    .wdata_i   (wdata_i),
    .gsts_o    (gsts),
    .gmsk_o    (gmsk),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (is_ch) begin
      if (ch_ofs == CH_STRIDE_LOG2'(CH_STS_OFS))      rdata_o = DW'(ch_sts[ch_idx]);
      else if (ch_ofs == CH_STRIDE_LOG2'(CH_MSK_OFS)) rdata_o = DW'(ch_msk[ch_idx]);
    end else if (g_sel_gsts) rdata_o = gsts;
    else if (g_sel_gmsk)     rdata_o = gmsk;
    else if (g_sel_cfg)      rdata_o = DW'(en);
    else if (g_sel_sum)      rdata_o = DW'(summary);
    else if (g_sel_smsk)     rdata_o = DW'(smsk);
  end

  // cascade check: the channel-pending bit may only be visible when some channel is pending
  assert_chbit_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsts[CHIRQ_BIT] |-> (summary != '0));
endmodule

// File: tb/sim_usb_irq_aggregator.sv
module sim_usb_irq_aggregator;
  localparam int NUM_CH = 16;
  localparam int CH_W   = 8;
  localparam int AW     = 8;

  localparam logic [2:0] OP_WR = 3'd1, OP_RD = 3'd2, OP_CS = 3'd3, OP_GS = 3'd4, OP_IRQ = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  8'h00, 32'h0, 32'h0, 4'd8},          // R8 gsts reset
    '{OP_RD,  8'h02, 32'h0, 32'h0, 4'd8},          // R8 enable off
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 4'd8},          // R8 irq low
    '{OP_CS,  8'd3,  32'h05, 32'h0, 4'd5},         // R5 raise ch3
    '{OP_RD,  8'h9A, 32'h0, 32'h05, 4'd5},         // R5
    '{OP_RD,  8'h04, 32'h0, 32'h0, 4'd2},          // R2 mask zero
    '{OP_WR,  8'h9B, 32'h04, 32'h0, 4'd4},
    '{OP_RD,  8'h04, 32'h0, 32'h08, 4'd2},         // R2 summary bit 3
    '{OP_RD,  8'h9B, 32'h0, 32'h04, 4'd4},         // R4 mask word
    '{OP_RD,  8'h00, 32'h0, 32'h0, 4'd3},          // R3 summary masked
    '{OP_WR,  8'h05, 32'h08, 32'h0, 4'd3},
    '{OP_RD,  8'h00, 32'h0, 32'h0200_0000, 4'd3},  // R3 channel pending
    '{OP_WR,  8'h01, 32'h0200_0000, 32'h0, 4'd1},
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 4'd10},         // R10 disabled
    '{OP_WR,  8'h02, 32'h1, 32'h0, 4'd10},
    '{OP_IRQ, 8'h00, 32'h0, 32'h1, 4'd1},          // R1
    '{OP_WR,  8'h00, 32'h0200_0000, 32'h0, 4'd3},
    '{OP_RD,  8'h00, 32'h0, 32'h0200_0000, 4'd3},  // R3 read-only bit
    '{OP_WR,  8'h9A, 32'h01, 32'h0, 4'd6},
    '{OP_RD,  8'h9A, 32'h0, 32'h04, 4'd6},         // R6 partial clear
    '{OP_RD,  8'h04, 32'h0, 32'h08, 4'd6},         // R6
    '{OP_WR,  8'h9A, 32'h04, 32'h0, 4'd6},
    '{OP_RD,  8'h04, 32'h0, 32'h0, 4'd2},          // R2 summary drops
    '{OP_RD,  8'h00, 32'h0, 32'h0, 4'd3},          // R3 pending drops
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 4'd1},          // R1
    '{OP_GS,  8'h00, 32'h0200_0011, 32'h0, 4'd7},
    '{OP_RD,  8'h00, 32'h0, 32'h11, 4'd7},         // R7 bit 25 ignored
    '{OP_WR,  8'h00, 32'h01, 32'h0, 4'd7},
    '{OP_RD,  8'h00, 32'h0, 32'h10, 4'd7},         // R7 w1c
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 4'd1},          // R1 masked
    '{OP_WR,  8'h01, 32'h10, 32'h0, 4'd1},
    '{OP_IRQ, 8'h00, 32'h0, 32'h1, 4'd1},          // R1
    '{OP_CS,  8'd15, 32'hFF, 32'h0, 4'd5},
    '{OP_WR,  8'hFB, 32'h80, 32'h0, 4'd4},
    '{OP_RD,  8'hFA, 32'h0, 32'hFF, 4'd5},         // R5 last channel
    '{OP_RD,  8'h04, 32'h0, 32'h8000, 4'd9},       // R9
    '{OP_WR,  8'h05, 32'hFFFF_FFFF, 32'h0, 4'd9},
    '{OP_RD,  8'h05, 32'h0, 32'h0000_FFFF, 4'd9},  // R9 width
    '{OP_RD,  8'h00, 32'h0, 32'h0200_0010, 4'd3},  // R3
    '{OP_RD,  8'h9C, 32'h0, 32'h0, 4'd4},          // R4 unused word
    '{OP_RD,  8'h8B, 32'h0, 32'h0, 4'd4}           // R4 ch1 mask untouched
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0;
  logic [31:0] wdata = '0, glb_set = '0;
  logic [NUM_CH*CH_W-1:0] ch_set = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  usb_irq_aggregator u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .ch_set_i(ch_set), .glb_set_i(glb_set), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk); addr = a; #1;
    check(req, rdata, e);
  endtask

  initial begin
    @(posedge clk);
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    foreach (VEC[i]) begin
      vec_t v;
      v = VEC[i];
      case (v.op)
        OP_WR: wr_reg(v.addr, v.data);
        OP_RD: rd_chk($sformatf("R%0d vec%0d", v.req, i), v.addr, v.exp);
        OP_CS: begin
          @(negedge clk); ch_set[int'(v.addr)*CH_W +: CH_W] = v.data[CH_W-1:0];
          @(negedge clk); ch_set = '0;
        end
        OP_GS: begin
          @(negedge clk); glb_set = v.data;
          @(negedge clk); glb_set = '0;
        end
        OP_IRQ: begin
          @(negedge clk);
          check($sformatf("R%0d vec%0d irq", v.req, i), 32'(irq), v.exp);
        end
        default: ;
      endcase
    end

    // R5: set and clear of the same bit in one cycle, set wins
    @(negedge clk);
    ch_set[0 +: CH_W] = 8'h02; addr = 8'h82; wdata = 32'h02; wr = 1'b1;
    @(negedge clk); ch_set = '0; wr = 1'b0;
    rd_chk("R5 set-over-clear", 8'h82, 32'h02);
    // R5: raising an already set bit keeps the value
    @(negedge clk); ch_set[0 +: CH_W] = 8'h02;
    @(negedge clk); ch_set = '0;
    rd_chk("R5 re-raise", 8'h82, 32'h02);

    // R7: re-raising a set global bit changes nothing
    @(negedge clk); glb_set = 32'h10;
    @(negedge clk); glb_set = '0;
    rd_chk("R7 re-raise", 8'h00, 32'h0200_0010);

    // R1: irq falls exactly one cycle after the mask clears
    @(negedge clk); addr = 8'h01; wdata = 32'h0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    check("R1 latency hold", 32'(irq), 32'h1);
    @(negedge clk);
    check("R1 latency fall", 32'(irq), 32'h0);

    // R10: disabling blocks an otherwise pending interrupt
    wr_reg(8'h01, 32'h10);
    @(negedge clk);
    check("R10 pre", 32'(irq), 32'h1);
    wr_reg(8'h02, 32'h0);
    @(negedge clk);
    check("R10 disabled", 32'(irq), 32'h0);
    wr_reg(8'h02, 32'h1);

    // R8: reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 irq", 32'(irq), 32'h0);
    rst_ni = 1'b1;
    rd_chk("R8 gsts", 8'h00, 32'h0);
    rd_chk("R8 cfg", 8'h02, 32'h0);
    rd_chk("R8 gmsk", 8'h01, 32'h0);
    rd_chk("R8 sum", 8'h04, 32'h0);
    rd_chk("R8 smsk", 8'h05, 32'h0);
    rd_chk("R8 ch15 sts", 8'hFA, 32'h0);
    rd_chk("R8 ch3 msk", 8'h9B, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule